// File: doc/BRIEF.md
# Double-to-Single Round-to-Odd Narrowing Converter

This block narrows an IEEE-754 binary64 operand to binary32 using round-to-odd, also called von Neumann rounding. It first truncates toward zero. If any bit that was dropped is nonzero, it forces the least significant bit of the result to one. An intermediate narrowed this way can be rounded again to a still smaller format without double-rounding error. The block has no rounding-mode input: the rule is fixed.

An operand is presented with a one-cycle strobe. The registered result and its valid strobe appear on the next clock edge. Each result carries one-cycle exception pulses for inexact, underflow, overflow and invalid. The same events are OR-accumulated into a sticky flag vector that only reset clears.

The block handles normals, subnormals produced by the narrowing, source subnormals, signed zeros, infinities, and both kinds of NaN. All format widths are parameters. The defaults are the binary64-to-binary32 pair.

Top module: `fp_narrow_rto`

## Requirements
- R1: A normal operand whose source exponent field e satisfies 896 < e < 1151 converts as follows. The sign is kept. The exponent field becomes e − 896. The fraction becomes source fraction bits 51:29. When source fraction bits 28:0 are all zero, no flag is raised.
- R2: When any dropped source bit is nonzero, result bit 0 is forced to 1 and the inexact pulse is raised. This holds for every finite, non-overflowing, non-NaN input. The other result bits are the truncated value.
- R3: A finite operand with e ≥ 1151 returns the largest finite binary32 of the same sign (magnitude 0x7F7FFFFF). It raises overflow and inexact.
- R4: A normal operand with e ≤ 896 returns exponent field 0. The fraction is the 53-bit significand shifted right by (926 − e), and bit 0 is forced to 1 if any shifted-out bit was nonzero. Underflow and inexact are raised together, and only when such bits were lost.
- R5: A source subnormal (e = 0, fraction ≠ 0) returns the sign with magnitude 0x00000001. It raises underflow and inexact.
- R6: Signed zeros and signed infinities convert exactly, keeping their sign, with no flag.
- R7: A signaling NaN (e all ones, fraction ≠ 0, fraction bit 51 = 0) raises invalid. It returns the sign, exponent 0xFF, result fraction bit 22 = 1, and result fraction bits 21:0 = source fraction bits 50:29.
- R8: A quiet NaN (fraction bit 51 = 1) returns the sign, exponent 0xFF and source fraction bits 51:29, with no flag.
- R9: out_valid equals in_valid delayed by one clock. out_data holds its last value while no operand arrives. flag_pulse is zero whenever out_valid is low.
- R10: flag_pulse and flag_sticky use bit 3 = invalid, bit 2 = overflow, bit 1 = underflow, bit 0 = inexact. The sticky vector ORs in each result's pulses in the cycle that result appears. It never clears a bit except on reset, which sets it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 32 | binary32 result |
| flag_pulse | output | 4 | Exceptions of the current result |
| flag_sticky | output | 4 | Accumulated exceptions since reset |

## Verification
On every cycle, the assertions check the following properties:
- the one-cycle strobe latency and the silence of the pulses between results;
- that sticky bits never fall and always cover the current pulses;
- that overflow and underflow never appear without inexact;
- that any inexact non-NaN result is odd;
- that an invalid result is a quiet NaN.

The exact bit patterns need the bench's sweep, which an arithmetic model checks across every source exponent, both signs and several fraction patterns. These patterns include the normal-to-subnormal boundary at 896/897 and the overflow edge at 1150/1151. Only the bench's scenarios also show that results hold between operands and that reset clears the sticky vector.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_SUB  = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_QNAN = 3'd4,
        CL_SNAN = 3'd5
    } fclass_t;

    // Bit order is behaviour: {invalid, overflow, underflow, inexact}
    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;

endpackage

// File: rtl/fp_src_classify.sv
module fp_src_classify
    import fp_narrow_pkg::*;
#(
    parameter int SE = 11,
    parameter int SF = 52
) (
    input  logic [SE+SF:0] word_i,
    output fclass_t        cls_o,
    output logic           sgn_o,
    output logic [SE-1:0]  exp_o,
    output logic [SF-1:0]  frac_o
);
    always_comb begin
        sgn_o  = word_i[SE+SF];
        exp_o  = word_i[SE+SF-1 -: SE];
        frac_o = word_i[SF-1:0];
        if (&exp_o) begin
            if (frac_o == '0)        cls_o = CL_INF;
            else if (frac_o[SF-1])   cls_o = CL_QNAN;
            else                     cls_o = CL_SNAN;
        end else if (exp_o == '0) begin
            cls_o = (frac_o == '0) ? CL_ZERO : CL_SUB;
        end else begin
            cls_o = CL_NORM;
        end
    end
endmodule

// File: rtl/fp_narrow_core.sv
module fp_narrow_core
    import fp_narrow_pkg::*;
#(
    parameter int SE = 11,
    parameter int SF = 52,
    parameter int DE = 8,
    parameter int DF = 23,
    localparam int DW = 1 + DE + DF
) (
    input  fclass_t        cls_i,
    input  logic           sgn_i,
    input  logic [SE-1:0]  exp_i,
    input  logic [SF-1:0]  frac_i,
    output logic [DW-1:0]  res_o,
    output exc_t           flg_o
);
    localparam int FW      = SF - DF;
    localparam int SBIAS   = (1 << (SE - 1)) - 1;
    localparam int DBIAS   = (1 << (DE - 1)) - 1;
    localparam int REB     = SBIAS - DBIAS;
    localparam int OVF_E   = REB + (1 << DE) - 1;
    localparam int SH0     = REB + FW + 1;
    localparam int CLAMP_E = SH0 - (SF + 1);
    localparam int SHW     = $clog2(SF + 2);

    localparam logic [SE-1:0] REB_V   = SE'(REB);
    localparam logic [SE-1:0] OVF_V   = SE'(OVF_E);
    localparam logic [SE-1:0] CLAMP_V = SE'(CLAMP_E);
    localparam logic [DE-1:0] DMAXE   = {DE{1'b1}};

    logic [SF:0]     mant;
    logic [SE-1:0]   exp_eff;
    logic [SHW-1:0]  sh_c;
    logic            lost;

    always_comb begin
        res_o   = '0;
        flg_o   = '0;
        mant    = {1'b1, frac_i};
        exp_eff = exp_i;
        sh_c    = '0;
        lost    = 1'b0;
        case (cls_i)
            CL_ZERO: res_o = {sgn_i, {(DW-1){1'b0}}};
            CL_INF:  res_o = {sgn_i, DMAXE, {DF{1'b0}}};
            CL_QNAN: res_o = {sgn_i, DMAXE, frac_i[SF-1 -: DF]};
            CL_SNAN: begin
                res_o         = {sgn_i, DMAXE, 1'b1, frac_i[SF-2 -: DF-1]};
                flg_o.invalid = 1'b1;
            end
            default: begin
                if (cls_i == CL_SUB) begin
                    mant    = {1'b0, frac_i};
                    exp_eff = SE'(1);
                end
                if (exp_eff >= OVF_V) begin
                    // truncation toward zero saturates to max finite
                    res_o          = {sgn_i, DMAXE - DE'(1), {DF{1'b1}}};
                    flg_o.overflow = 1'b1;
                    flg_o.inexact  = 1'b1;
                end else if (exp_eff > REB_V) begin
                    lost          = |frac_i[FW-1:0];
                    res_o         = {sgn_i, DE'(exp_eff - REB_V), frac_i[SF-1 -: DF]};
                    res_o[0]      = res_o[0] | lost;
                    flg_o.inexact = lost;
                end else begin
                    if (exp_eff < CLAMP_V) begin
                        lost  = |mant;
                        res_o = {sgn_i, {(DW-1){1'b0}}};
                    end else begin
                        sh_c  = SHW'(SH0 - int'(exp_eff));
                        lost  = |(mant & ~({(SF+1){1'b1}} << sh_c));
                        res_o = {sgn_i, {DE{1'b0}}, DF'(mant >> sh_c)};
                    end
                    res_o[0]        = res_o[0] | lost;
                    flg_o.inexact   = lost;
                    flg_o.underflow = lost;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp_narrow_rto.sv
module fp_narrow_rto
    import fp_narrow_pkg::*;
#(
    parameter int SE = 11,
    parameter int SF = 52,
    parameter int DE = 8,
    parameter int DF = 23,
    localparam int SW = 1 + SE + SF,
    localparam int DW = 1 + DE + DF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [3:0]    flag_pulse,
    output logic [3:0]    flag_sticky
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] result;
        exc_t          pulse;
        exc_t          sticky;
    } state_t;

    state_t         st_d, st_q;
    fclass_t        cls;
    logic           sgn;
    logic [SE-1:0]  sexp;
    logic [SF-1:0]  sfrac;
    logic [DW-1:0]  conv_res;
    exc_t           conv_flg;

    fp_src_classify #(.SE(SE), .SF(SF)) u_classify (
        .word_i (in_data),
        .cls_o  (cls),
        .sgn_o  (sgn),
        .exp_o  (sexp),
        .frac_o (sfrac)
    );

    fp_narrow_core #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_core (
        .cls_i  (cls),
        .sgn_i  (sgn),
        .exp_i  (sexp),
        .frac_i (sfrac),
        .res_o  (conv_res),
        .flg_o  (conv_flg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.pulse = '0;
        if (in_valid) begin
            st_d.result = conv_res;
            st_d.pulse  = conv_flg;
            st_d.sticky = st_q.sticky | conv_flg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_data    = st_q.result;
    assign flag_pulse  = st_q.pulse;
    assign flag_sticky = st_q.sticky;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_quiet_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (flag_pulse == 4'b0));
    p_sticky_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_sticky & $past(flag_sticky)) == $past(flag_sticky)));
    p_sticky_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_sticky & flag_pulse) == flag_pulse);
    p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pulse[2] |-> (flag_pulse[0] && out_data[DW-2:0] == {{(DE-1){1'b1}}, 1'b0, {DF{1'b1}}}));
    p_unf_tiny_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pulse[1] |-> (flag_pulse[0] && out_data[DW-2 -: DE] == '0));
    p_odd_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_pulse[0] && !flag_pulse[3]) |-> out_data[0]);
    p_quiet_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pulse[3] |-> (&out_data[DW-2 -: DE] && out_data[DF-1] && flag_pulse[2:0] == 3'b0));
endmodule

// File: tb/fp_narrow_rto_tb.sv
module fp_narrow_rto_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  flag_pulse;
    logic [3:0]  flag_sticky;

    int errors = 0;
    int checks = 0;
    logic [3:0]  exp_sticky = '0;
    logic [31:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_narrow_rto u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .flag_pulse(flag_pulse), .flag_sticky(flag_sticky)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp, input logic [63:0] op);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    // Arithmetic model: value = m * 2^L, leading exponent X, target lsb exponent T
    task automatic ref_conv(input logic [63:0] x, output logic [31:0] r,
                            output logic [3:0] fl, output string tag);
        logic        s;
        int          e;
        logic [51:0] f;
        logic [63:0] m, keep;
        int          lexp, msb, xe, te, sh;
        bit          inex;
        s = x[63]; e = int'(x[62:52]); f = x[51:0];
        fl = 4'b0;
        r = '0;
        if (e == 2047) begin
            if (f == 0) begin r = {s, 8'hFF, 23'h0}; tag = "R6"; end
            else if (!f[51]) begin r = {s, 8'hFF, 1'b1, f[50:29]}; fl = 4'b1000; tag = "R7"; end
            else begin r = {s, 8'hFF, f[51:29]}; tag = "R8"; end
        end else if (e == 0 && f == 0) begin
            r = {s, 31'h0}; tag = "R6";
        end else begin
            m = {11'h0, (e != 0), f};
            lexp = ((e == 0) ? 1 : e) - 1075;
            msb = -1;
            for (int i = 52; i >= 0; i--) if (m[i] && msb < 0) msb = i;
            xe = lexp + msb;
            if (xe > 127) begin
                r = {s, 8'hFE, 23'h7FFFFF}; fl = 4'b0101; tag = "R3";
            end else begin
                te = ((xe < -126) ? -126 : xe) - 23;
                sh = te - lexp;
                if (sh >= 64) begin keep = '0; inex = 1'b1; end
                else begin keep = m >> sh; inex = ((keep << sh) != m); end
                if (keep >= 64'h800000) r = {s, 8'(xe + 127), keep[22:0]};
                else                    r = {s, 8'h00, keep[22:0]};
                r[0] = r[0] | inex;
                fl[0] = inex;
                fl[1] = inex && (xe < -126);
                if (e == 0)           tag = "R5";
                else if (xe < -126)   tag = "R4";
                else if (inex)        tag = "R2";
                else                  tag = "R1";
            end
        end
    endtask

    function automatic logic [51:0] frac_pat(input int k);
        case (k)
            0: return 52'h0;
            1: return 52'h1;
            2: return 52'h0_0000_2000_0000;
            3: return 52'h0_0000_1FFF_FFFF;
            4: return 52'hF_FFFF_FFFF_FFFF;
            5: return 52'h8_0000_0000_0000;
            default: return 52'h5_A5C3_6000_0001;
        endcase
    endfunction

    task automatic apply(input logic [63:0] x);
        logic [31:0] er;
        logic [3:0]  ef;
        string       tag;
        ref_conv(x, er, ef, tag);
        @(negedge clk);
        // R9: idle cycle before this operand, result held, pulses silent
        check(!out_valid && flag_pulse == 4'b0, "R9", {out_valid, flag_pulse}, 64'h0, x);
        check(out_data == last_res, "R9", out_data, last_res, x);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9", out_valid, 1, x);
        check(out_data == er, tag, out_data, er, x);
        check(flag_pulse == ef, tag, flag_pulse, ef, x);
        exp_sticky = exp_sticky | ef;
        check(flag_sticky == exp_sticky, "R10", flag_sticky, exp_sticky, x);
        last_res = er;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] er;
        logic [3:0]  ef;
        logic [31:0] q_res [0:7];
        logic [3:0]  q_flg [0:7];
        logic [63:0] q_op  [0:7];
        string       tag;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(out_valid == 0 && flag_pulse == 0 && flag_sticky == 0 && out_data == 0,
              "R10", {out_valid, flag_pulse, flag_sticky, out_data}, 64'h0, 64'h0);
        rst_n = 1'b1;

        // Sweep every source exponent, both signs, several fractions (R1-R8 by tag)
        for (int e = 0; e < 2048; e++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 7; k++)
                    apply({s[0], e[10:0], frac_pat(k)});

        // R9 back-to-back operands: each result one cycle after its strobe
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check(out_valid == 1'b1, "R9", out_valid, 1, q_op[i-1]);
                check(out_data == q_res[i-1] && flag_pulse == q_flg[i-1], "R9",
                      {out_data, flag_pulse}, {q_res[i-1], q_flg[i-1]}, q_op[i-1]);
            end
            if (i < 8) begin
                q_op[i] = {i[0], 11'(890 + i), 52'h0_0000_0000_0003 << i};
                ref_conv(q_op[i], er, ef, tag);
                q_res[i] = er; q_flg[i] = ef;
                in_valid = 1'b1; in_data = q_op[i];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R9", out_valid, 0, 64'h0);

        // R10: sticky cleared only by reset
        rst_n = 1'b0;
        @(negedge clk);
        check(flag_sticky == 4'b0, "R10", flag_sticky, 0, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(flag_sticky == 4'b0, "R10", flag_sticky, 0, 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule